// File: doc/BRIEF.md
# CAN Interrupt Flag Aggregator

This block collects the event pulses of a CAN controller and turns them into interrupt requests. Each message object reports received-OK, transmitted-OK and three kinds of object error. The controller as a whole reports a general error, a buffer-full condition and a timer overrun. Every pulse sets a sticky flag. The flag stays set until software clears it by writing a one to its bit. A hierarchy of enables decides which flags reach the single CAN interrupt line. The timer overrun has its own enable and its own output line.

For each message object a pending bit is kept. It is the OR of that object's flags that pass the per-kind enables and the object's own enable. The pending bit clears by itself once software has cleared those flags. The pending vector can be read through the register port and is also brought out as a port.

An error recorded against a message object never raises a general flag. A form error seen while the node is transmitting also records a bit error on the same object. Software therefore sees two error causes for one fault and may take two interrupts, one after the other. The register port is a plain write strobe with address and data, plus a combinational read by address.

Top module: `can_irq_hub`

## Requirements
- R1: After reset all flags, all enables, the pending vector, `canIrq` and `timerIrq` are 0, and every register reads 0.
- R2: A one-cycle event pulse sets its flag at the next clock edge. In an object status register (address 4+i) the bits are: 0 = receive OK, 1 = transmit OK, 2 = bit error, 3 = form error, 4 = acknowledge error. In the general register (address 2) the bits are: 0 = general error, 1 = buffer full, 2 = timer overrun.
- R3: Flags are sticky. Writing a one to a bit of a status register clears that flag. Writing a zero leaves the flag unchanged.
- R4: When an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R5: A form-error pulse while `txBusy` is 1 sets both the form-error bit and the bit-error bit of that object. While `txBusy` is 0 it sets only the form-error bit.
- R6: Object error and object status events never set any general flag.
- R7: pending[i] = objEn[i] AND ((rxOk AND rxOkEn) OR (txOk AND txOkEn) OR (any of the three error bits AND objErrEn)). The vector is readable at address 3. It drops to 0 once the flags that caused it are cleared.
- R8: `canIrq` is registered. One cycle after the state changes it equals canEn AND (any pending bit OR (generalError AND genErrEn) OR (bufferFull AND bufEn)).
- R9: `timerIrq` is registered and equals ovrEn AND timerOverrun one cycle later, whatever the value of canEn. The timer overrun never drives `canIrq`.
- R10: The configuration register at address 0 holds bit0 canEn, bit1 genErrEn, bit2 bufEn, bit3 ovrEn, bit4 rxOkEn, bit5 txOkEn and bit6 objErrEn. Address 1 holds the per-object enable vector. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data (write-one-to-clear for status registers) |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read data |
| evRxOk | input | NUM_OBJ | Per-object receive-OK pulses |
| evTxOk | input | NUM_OBJ | Per-object transmit-OK pulses |
| evBitErr | input | NUM_OBJ | Per-object bit-error pulses |
| evFormErr | input | NUM_OBJ | Per-object form-error pulses |
| evAckErr | input | NUM_OBJ | Per-object acknowledge-error pulses |
| txBusy | input | 1 | Node is currently transmitting |
| evGenErr | input | 1 | General error pulse |
| evBufFull | input | 1 | Buffer-full pulse |
| evTimerOvr | input | 1 | Timer overrun pulse |
| objPending | output | NUM_OBJ | Per-object pending vector |
| canIrq | output | 1 | CAN interrupt line (level) |
| timerIrq | output | 1 | Timer overrun interrupt line (level) |

## Verification
The assertions assume that event inputs are single-cycle pulses driven between clock edges. They also assume that `txBusy` is steady across a form-error pulse, so the bit-error implication is sampled on the same edge as the form error. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It only ever issues simultaneous set and clear on purpose, in the set-wins case. Configuration and enables are written only through the register port. In the sweep, every configuration value meets several event mixes, and the bench compares the lines and the pending vector with its own flag model.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  // per-object flag positions
  localparam int KIND_W   = 5;
  localparam int K_RX     = 0;
  localparam int K_TX     = 1;
  localparam int K_BIT    = 2;
  localparam int K_FORM   = 3;
  localparam int K_ACK    = 4;

  // general flag positions
  localparam int GEN_W    = 3;
  localparam int G_ERR    = 0;
  localparam int G_BUF    = 1;
  localparam int G_OVR    = 2;

  // register addresses
  localparam int ADDR_CFG   = 0;
  localparam int ADDR_OBJEN = 1;
  localparam int ADDR_GEN   = 2;
  localparam int ADDR_PEND  = 3;
  localparam int ADDR_OBJ0  = 4;

  localparam int CFG_W = 7;

  // bit0 is canEn
  typedef struct packed {
    logic objErrEn;
    logic txOkEn;
    logic rxOkEn;
    logic ovrEn;
    logic bufEn;
    logic genErrEn;
    logic canEn;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCfg;
    logic wrObjEn;
    logic clrGen;
    logic clrObj;
  } ctlStrobe_t;

endpackage

// File: rtl/can_irq_ctl.sv
module can_irq_ctl
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int ADDR_W  = 4,
  localparam int SEL_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctlStrobe_t        strobe,
  output logic [SEL_W-1:0]  objSel
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_OBJEN = ADDR_W'(ADDR_OBJEN);
  localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'(ADDR_GEN);
  localparam logic [ADDR_W-1:0] A_OBJ0  = ADDR_W'(ADDR_OBJ0);
  localparam logic [ADDR_W-1:0] A_OBJE  = ADDR_W'(ADDR_OBJ0 + NUM_OBJ);

  logic inObjRange;

  assign inObjRange = (wrAddr >= A_OBJ0) && (wrAddr < A_OBJE);

  always_comb begin
    strobe = '0;
    objSel = SEL_W'(wrAddr - A_OBJ0);
    if (wrEn) begin
      if (wrAddr == A_CFG) begin
        strobe.wrCfg = 1'b1;
      end else if (wrAddr == A_OBJEN) begin
        strobe.wrObjEn = 1'b1;
      end else if (wrAddr == A_GEN) begin
        strobe.clrGen = 1'b1;
      end else if (inObjRange) begin
        strobe.clrObj = 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_irq_objcell.sv
module can_irq_objcell
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evRx,
  input  logic              evTx,
  input  logic              evBit,
  input  logic              evForm,
  input  logic              evAck,
  input  logic              txBusy,
  input  logic [KIND_W-1:0] clrMask,
  input  logic [KIND_W-1:0] kindMask,
  input  logic              objEn,
  output logic [KIND_W-1:0] flags,
  output logic              pending
);

  logic [KIND_W-1:0] setVec;

  always_comb begin
    setVec         = '0;
    setVec[K_RX]   = evRx;
    setVec[K_TX]   = evTx;
    // a form error while sending is also a bit error
    setVec[K_BIT]  = evBit | (evForm & txBusy);
    setVec[K_FORM] = evForm;
    setVec[K_ACK]  = evAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      // set after clear: a new event is never lost
      flags <= (flags & ~clrMask) | setVec;
    end
  end

  assign pending = objEn & (|(flags & kindMask));

endmodule

// File: rtl/can_irq_dp.sv
module can_irq_dp
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic [SEL_W-1:0]               objSel,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [DATA_W-1:0]              rdData,
  input  logic [NUM_OBJ-1:0]             evRxOk,
  input  logic [NUM_OBJ-1:0]             evTxOk,
  input  logic [NUM_OBJ-1:0]             evBitErr,
  input  logic [NUM_OBJ-1:0]             evFormErr,
  input  logic [NUM_OBJ-1:0]             evAckErr,
  input  logic                           txBusy,
  input  logic                           evGenErr,
  input  logic                           evBufFull,
  input  logic                           evTimerOvr,
  output cfg_t                           cfgOut,
  output logic [GEN_W-1:0]               genFlags,
  output logic [NUM_OBJ-1:0][KIND_W-1:0] objFlags,
  output logic [NUM_OBJ-1:0]             objPending,
  output logic                           canIrq,
  output logic                           timerIrq
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_OBJEN = ADDR_W'(ADDR_OBJEN);
  localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'(ADDR_GEN);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(ADDR_PEND);
  localparam logic [ADDR_W-1:0] A_OBJ0  = ADDR_W'(ADDR_OBJ0);
  localparam logic [ADDR_W-1:0] A_OBJE  = ADDR_W'(ADDR_OBJ0 + NUM_OBJ);

  cfg_t               cfgQ;
  logic [NUM_OBJ-1:0] objEnQ;
  logic [GEN_W-1:0]   genQ;
  logic [GEN_W-1:0]   genSet;
  logic [GEN_W-1:0]   genClr;
  logic [KIND_W-1:0]  kindMask;
  logic               canNext;
  logic               timerNext;

  // configuration and object enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      objEnQ <= '0;
    end else begin
      if (strobe.wrCfg)   cfgQ   <= cfg_t'(wrData[CFG_W-1:0]);
      if (strobe.wrObjEn) objEnQ <= wrData[NUM_OBJ-1:0];
    end
  end

  // general flags
  always_comb begin
    genSet        = '0;
    genSet[G_ERR] = evGenErr;
    genSet[G_BUF] = evBufFull;
    genSet[G_OVR] = evTimerOvr;
    genClr        = strobe.clrGen ? wrData[GEN_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) genQ <= '0;
    else       genQ <= (genQ & ~genClr) | genSet;
  end

  // per-kind mask shared by all objects
  always_comb begin
    kindMask         = '0;
    kindMask[K_RX]   = cfgQ.rxOkEn;
    kindMask[K_TX]   = cfgQ.txOkEn;
    kindMask[K_BIT]  = cfgQ.objErrEn;
    kindMask[K_FORM] = cfgQ.objErrEn;
    kindMask[K_ACK]  = cfgQ.objErrEn;
  end

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
    logic [KIND_W-1:0] clrMask;
    assign clrMask = (strobe.clrObj && (objSel == SEL_W'(i))) ? wrData[KIND_W-1:0] : '0;

    can_irq_objcell uCell (
      .clk      (clk),
      .rstN     (rstN),
      .evRx     (evRxOk[i]),
      .evTx     (evTxOk[i]),
      .evBit    (evBitErr[i]),
      .evForm   (evFormErr[i]),
      .evAck    (evAckErr[i]),
      .txBusy   (txBusy),
      .clrMask  (clrMask),
      .kindMask (kindMask),
      .objEn    (objEnQ[i]),
      .flags    (objFlags[i]),
      .pending  (objPending[i])
    );
  end

  // interrupt lines
  assign canNext = cfgQ.canEn & ((|objPending)
                                 | (genQ[G_ERR] & cfgQ.genErrEn)
                                 | (genQ[G_BUF] & cfgQ.bufEn));
  assign timerNext = cfgQ.ovrEn & genQ[G_OVR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      canIrq   <= 1'b0;
      timerIrq <= 1'b0;
    end else begin
      canIrq   <= canNext;
      timerIrq <= timerNext;
    end
  end

  // read mux
  logic [SEL_W-1:0] rdIdx;
  assign rdIdx = SEL_W'(rdAddr - A_OBJ0);

  always_comb begin
    rdData = '0;
    if (rdAddr == A_CFG) begin
      rdData = DATA_W'(cfgQ);
    end else if (rdAddr == A_OBJEN) begin
      rdData = DATA_W'(objEnQ);
    end else if (rdAddr == A_GEN) begin
      rdData = DATA_W'(genQ);
    end else if (rdAddr == A_PEND) begin
      rdData = DATA_W'(objPending);
    end else if ((rdAddr >= A_OBJ0) && (rdAddr < A_OBJE)) begin
      rdData = DATA_W'(objFlags[rdIdx]);
    end
  end

  assign cfgOut   = cfgQ;
  assign genFlags = genQ;

endmodule

// File: rtl/can_irq_hub.sv
module can_irq_hub
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_OBJ-1:0] evRxOk,
  input  logic [NUM_OBJ-1:0] evTxOk,
  input  logic [NUM_OBJ-1:0] evBitErr,
  input  logic [NUM_OBJ-1:0] evFormErr,
  input  logic [NUM_OBJ-1:0] evAckErr,
  input  logic               txBusy,
  input  logic               evGenErr,
  input  logic               evBufFull,
  input  logic               evTimerOvr,
  output logic [NUM_OBJ-1:0] objPending,
  output logic               canIrq,
  output logic               timerIrq
);

  localparam int SEL_W = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;

  ctlStrobe_t                     strobe;
  logic [SEL_W-1:0]               objSel;
  cfg_t                           cfgOut;
  logic [GEN_W-1:0]               genFlags;
  logic [NUM_OBJ-1:0][KIND_W-1:0] objFlags;

  can_irq_ctl #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) uCtl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe),
    .objSel (objSel)
  );

  can_irq_dp #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .objSel     (objSel),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .evRxOk     (evRxOk),
    .evTxOk     (evTxOk),
    .evBitErr   (evBitErr),
    .evFormErr  (evFormErr),
    .evAckErr   (evAckErr),
    .txBusy     (txBusy),
    .evGenErr   (evGenErr),
    .evBufFull  (evBufFull),
    .evTimerOvr (evTimerOvr),
    .cfgOut     (cfgOut),
    .genFlags   (genFlags),
    .objFlags   (objFlags),
    .objPending (objPending),
    .canIrq     (canIrq),
    .timerIrq   (timerIrq)
  );

endmodule

// File: rtl/can_irq_hub_chk.sv
module can_irq_hub_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           evGenErr,
  input logic                           evBufFull,
  input logic [NUM_OBJ-1:0]             evFormErr,
  input logic                           txBusy,
  input logic                           clrGen,
  input logic [GEN_W-1:0]               wrLow,
  input logic [GEN_W-1:0]               genFlags,
  input logic [NUM_OBJ-1:0][KIND_W-1:0] objFlags,
  input logic [NUM_OBJ-1:0]             objPending,
  input logic                           cfgCanEn,
  input logic                           cfgOvrEn,
  input logic                           canIrq,
  input logic                           timerIrq
);

  p_gen_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    evGenErr |=> genFlags[G_ERR]);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    genFlags[G_ERR] && !(clrGen && wrLow[G_ERR]) |=> genFlags[G_ERR]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    evBufFull && clrGen && wrLow[G_BUF] |=> genFlags[G_BUF]);

  p_no_gen_from_obj_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(genFlags[G_ERR]) |-> $past(evGenErr));

  p_can_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCanEn |=> !canIrq);

  p_timer_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOvrEn |=> !timerIrq);

  p_timer_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgOvrEn && genFlags[G_OVR] |=> timerIrq);

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_chk
    p_form_tx_r5: assert property (@(posedge clk) disable iff (!rstN)
      evFormErr[i] && txBusy |=> objFlags[i][K_BIT] && objFlags[i][K_FORM]);

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (objFlags[i] == '0) |-> !objPending[i]);
  end

endmodule

bind can_irq_hub can_irq_hub_chk #(.NUM_OBJ(NUM_OBJ)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .evGenErr   (evGenErr),
  .evBufFull  (evBufFull),
  .evFormErr  (evFormErr),
  .txBusy     (txBusy),
  .clrGen     (strobe.clrGen),
  .wrLow      (wrData[2:0]),
  .genFlags   (genFlags),
  .objFlags   (objFlags),
  .objPending (objPending),
  .cfgCanEn   (cfgOut.canEn),
  .cfgOvrEn   (cfgOut.ovrEn),
  .canIrq     (canIrq),
  .timerIrq   (timerIrq)
);

// File: tb/can_irq_hub_test.sv
`timescale 1ns/1ps
module can_irq_hub_test;

  localparam int NOBJ = 8;
  localparam int AW   = 4;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic [NOBJ-1:0] evRxOk = '0, evTxOk = '0, evBitErr = '0, evFormErr = '0, evAckErr = '0;
  logic txBusy = 1'b0, evGenErr = 1'b0, evBufFull = 1'b0, evTimerOvr = 1'b0;
  logic [NOBJ-1:0] objPending;
  logic canIrq, timerIrq;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [4:0] objM [NOBJ];
  logic [2:0] genM;
  logic [6:0] cfgM;
  logic [NOBJ-1:0] enM;

  always #2 clk = ~clk;

  can_irq_hub #(.NUM_OBJ(NOBJ), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evRxOk(evRxOk), .evTxOk(evTxOk),
    .evBitErr(evBitErr), .evFormErr(evFormErr), .evAckErr(evAckErr),
    .txBusy(txBusy), .evGenErr(evGenErr), .evBufFull(evBufFull),
    .evTimerOvr(evTimerOvr), .objPending(objPending), .canIrq(canIrq),
    .timerIrq(timerIrq)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic regWrite(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = DW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input int addr, output int data);
    rdAddr = AW'(addr);
    #0.5;
    data = int'(rdData);
  endtask

  task automatic setObjEv(input int o, input int k, input logic v);
    case (k)
      0: evRxOk[o] = v;
      1: evTxOk[o] = v;
      2: evBitErr[o] = v;
      3: evFormErr[o] = v;
      default: evAckErr[o] = v;
    endcase
  endtask

  // one-cycle object event, model updated
  task automatic pulseObj(input int o, input int k, input logic tx, input int g);
    @(negedge clk);
    setObjEv(o, k, 1'b1);
    txBusy = tx;
    evGenErr = g[0]; evBufFull = g[1]; evTimerOvr = g[2];
    @(negedge clk);
    setObjEv(o, k, 1'b0);
    txBusy = 1'b0; evGenErr = 1'b0; evBufFull = 1'b0; evTimerOvr = 1'b0;
    objM[o][k] = 1'b1;
    if (k == 3 && tx) objM[o][2] = 1'b1;
    genM = genM | 3'(g);
  endtask

  task automatic clearAll();
    for (int o = 0; o < NOBJ; o++) begin
      regWrite(4 + o, 'h1F);
      objM[o] = '0;
    end
    regWrite(2, 'h7);
    genM = '0;
  endtask

  function automatic int expPend();
    int p = 0;
    logic [4:0] km;
    km = {cfgM[6], cfgM[6], cfgM[6], cfgM[5], cfgM[4]};
    for (int o = 0; o < NOBJ; o++)
      if (enM[o] && |(objM[o] & km)) p |= (1 << o);
    return p;
  endfunction

  function automatic int expCan();
    return int'(cfgM[0] && (expPend() != 0 || (genM[0] && cfgM[1]) || (genM[1] && cfgM[2])));
  endfunction

  function automatic int expTimer();
    return int'(cfgM[3] && genM[2]);
  endfunction

  task automatic setCfg(input int c, input int en);
    regWrite(0, c); cfgM = 7'(c);
    regWrite(1, en); enM = NOBJ'(en);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    int rd;
    for (int o = 0; o < NOBJ; o++) objM[o] = '0;
    genM = '0; cfgM = '0; enM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 canIrq", int'(canIrq), 0);
    check("R1 timerIrq", int'(timerIrq), 0);
    check("R1 pending port", int'(objPending), 0);
    for (int a = 0; a < 4 + NOBJ; a++) begin
      regRead(a, rd);
      check("R1 register", rd, 0);
    end

    // R10 config readback
    setCfg('h7F, 'hFF);
    regRead(0, rd); check("R10 cfg readback", rd, 'h7F);
    regRead(1, rd); check("R10 objEn readback", rd, 'hFF);
    setCfg('h55, 'hA3);
    regRead(0, rd); check("R10 cfg readback", rd, 'h55);
    regRead(1, rd); check("R10 objEn readback", rd, 'hA3);

    // R2, R3 each kind on each object, then clear
    for (int o = 0; o < NOBJ; o++) begin
      for (int k = 0; k < 5; k++) begin
        pulseObj(o, k, 1'b0, 0);
        regRead(4 + o, rd); check("R2 object flag set", rd, 1 << k);
        regRead(2, rd); check("R6 general untouched", rd, 0);
        regWrite(4 + o, 1 << k); objM[o] = '0;
        regRead(4 + o, rd); check("R3 w1c clear", rd, 0);
      end
    end
    for (int g = 0; g < 3; g++) begin
      pulseObj(0, 0, 1'b0, 1 << g);
      regRead(2, rd); check("R2 general flag set", rd, 1 << g);
      clearAll();
    end

    // R3 sticky, zero write, partial clear
    pulseObj(2, 0, 1'b0, 0);
    pulseObj(2, 4, 1'b0, 0);
    repeat (5) @(negedge clk);
    regRead(6, rd); check("R3 sticky", rd, 'h11);
    regWrite(6, 'h00);
    regRead(6, rd); check("R3 zero write ignored", rd, 'h11);
    regWrite(6, 'h10);
    regRead(6, rd); check("R3 partial clear", rd, 'h01);
    clearAll();

    // R4 set wins over same-cycle clear
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(4); wrData = 'h1F; evRxOk[0] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evRxOk[0] = 1'b0;
    regRead(4, rd); check("R4 object set wins", rd, 'h01);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(2); wrData = 'h7; evBufFull = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evBufFull = 1'b0;
    regRead(2, rd); check("R4 general set wins", rd, 'h02);
    clearAll();

    // R5 form error with and without transmit
    pulseObj(3, 3, 1'b1, 0);
    regRead(7, rd); check("R5 form while sending", rd, 'h0C);
    pulseObj(5, 3, 1'b0, 0);
    regRead(9, rd); check("R5 form while idle", rd, 'h08);

    // R6 all object events on all objects, general stays clear
    for (int o = 0; o < NOBJ; o++)
      for (int k = 0; k < 5; k++) pulseObj(o, k, 1'b1, 0);
    regRead(2, rd); check("R6 general after object events", rd, 0);
    clearAll();

    // R7 pending masked by object enable, auto clear
    setCfg('h7F, 'hFE);
    pulseObj(0, 1, 1'b0, 0);
    pulseObj(1, 1, 1'b0, 0);
    regRead(3, rd); check("R7 pending masked", rd, 'h02);
    check("R7 pending port", int'(objPending), 'h02);
    regWrite(5, 'h02); objM[1] = '0;
    regRead(3, rd); check("R7 pending auto clear", rd, 0);
    @(negedge clk);
    check("R8 line drops", int'(canIrq), 0);
    clearAll();

    // R9 timer overrun separate from CAN line
    setCfg('h0F, 'hFF);
    pulseObj(0, 0, 1'b0, 4);
    @(negedge clk);
    check("R9 timer line set", int'(timerIrq), 1);
    check("R9 no CAN from overrun", int'(canIrq), 0);
    setCfg('h08, 'h00);
    @(negedge clk);
    check("R9 timer with canEn off", int'(timerIrq), 1);
    clearAll();

    // sweep: every configuration, several event mixes (R7, R8, R9)
    for (int c = 0; c < 128; c++) begin
      for (int p = 0; p < 4; p++) begin
        clearAll();
        setCfg(c, (p * 'h5B + c * 3) & 'hFF);
        pulseObj((c + p) % NOBJ, (c + p * 3) % 5, 1'(c[1]),
                 (p == 0) ? 0 : ((c * 5 + p) & 7));
        @(negedge clk);
        check("R8 canIrq sweep", int'(canIrq), expCan());
        check("R9 timerIrq sweep", int'(timerIrq), expTimer());
        regRead(3, rd); check("R7 pending sweep", rd, expPend());
      end
    end

    finishRun();
  end

endmodule